// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits between a per-warp instruction buffer and an eight-lane execution datapath. Each warp in the resident pool offers its next instruction, together with two source register numbers and one destination register number. In each issue slot the scheduler keeps only the warps whose next instruction has all of its registers free, according to a per-warp scoreboard. It picks one of them under a selectable priority rule and acknowledges the winner to the buffer. It then streams that single instruction to the datapath as four quarter-warp beats. Each beat carries a lane-group index, so the datapath knows which eight of the thirty-two threads it is serving.

Only one warp occupies the datapath at a time. The next winner is chosen during the final beat of the current warp, so a new warp's first beat follows the previous warp's last beat with no gap. The scoreboard marks a warp's destination register busy when that warp is selected. A writeback notification naming the warp and the register clears the mark. If no warp qualifies in a slot, the scheduler flags the following cycle as idle.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst_n` is low, `issue_valid`, `idle` and `warp_ack` are all 0. Reset clears every scoreboard bit and sets the rotation pointer so that warp 0 is searched first.
- R2: A warp is eligible only when its `warp_valid` bit is 1 and its scoreboard bits for the first source, the second source and the destination register are all clear.
- R3: Selecting a warp sets its scoreboard bit for its destination register. A writeback (`wb_valid`=1 with `wb_warp`, `wb_reg`) clears that bit from the next cycle, so it does not make a warp eligible in the cycle it is presented.
- R4: With `prio_mode`=0, the search starts at the warp after the last selected warp and wraps past the highest index to warp 0. Selections made under either mode update the last selected warp.
- R5: With `prio_mode`=1, the eligible warp with the lowest index wins.
- R6: `warp_ack` is a one-hot pulse for the winner in its selection cycle, and all zeros in every other cycle.
- R7: Starting the cycle after a selection, `issue_valid` stays 1 for four cycles while `issue_beat` counts 0, 1, 2, 3 (the lane group, each of eight threads), with `issue_warp` and `issue_instr` held.
- R8: Selection happens only in a cycle where `issue_valid` is 0 or `issue_beat` is 3. A warp chosen on beat 3 shows beat 0 in the very next cycle.
- R9: After a selection cycle with no eligible warp, the next cycle has `idle`=1 and `issue_valid`=0. `idle` and `issue_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warp_valid | input | NUM_WARPS | Per-warp: next instruction is present |
| instr_flat | input | NUM_WARPS*INSTR_W | Per-warp next instruction word |
| src_a_flat | input | NUM_WARPS*log2(NUM_REGS) | Per-warp first source register |
| src_b_flat | input | NUM_WARPS*log2(NUM_REGS) | Per-warp second source register |
| dst_flat | input | NUM_WARPS*log2(NUM_REGS) | Per-warp destination register |
| wb_valid | input | 1 | Writeback notification strobe |
| wb_warp | input | log2(NUM_WARPS) | Warp of the writeback |
| wb_reg | input | log2(NUM_REGS) | Register of the writeback |
| prio_mode | input | 1 | 0 rotating priority, 1 fixed lowest-index priority |
| warp_ack | output | NUM_WARPS | One-hot acknowledge of the selected warp |
| issue_valid | output | 1 | A beat is being sent to the datapath |
| issue_warp | output | log2(NUM_WARPS) | Warp being issued |
| issue_instr | output | INSTR_W | Instruction being issued |
| issue_beat | output | log2(WARP_SIZE/LANES) | Quarter-warp lane-group index |
| idle | output | 1 | No warp was eligible in the last slot |

## Verification
`warp_ack` is combinational, so the bench drives each slot's inputs just after a falling edge and reads the acknowledge 1 ns later, before the rising edge that commits the choice. Beat 0 is due at the next falling edge, and beats 1 to 3 follow at the next three falling edges. The beat 3 check is made at the same falling edge where the next slot's inputs are driven, which also proves there is no gap between warps. The idle flag is checked one falling edge after an empty slot. A writeback driven with a slot must leave that slot's result unchanged, and the effect is expected only in the slot after it.

// File: rtl/ws_pkg.sv
package ws_pkg;
   typedef enum logic {
      PRI_ROTATE = 1'b0,
      PRI_FIXED  = 1'b1
   } pri_mode_e;
endpackage

// File: rtl/ws_scoreboard.sv
module ws_scoreboard #(
   parameter int NW = 16,
   parameter int NR = 16,
   localparam int WW = (NW > 1) ? $clog2(NW) : 1,
   localparam int RW = (NR > 1) ? $clog2(NR) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [WW-1:0]    set_warp,
   input  logic [RW-1:0]    set_reg,
   input  logic             clr_en,
   input  logic [WW-1:0]    clr_warp,
   input  logic [RW-1:0]    clr_reg,
   output logic [NW*NR-1:0] busy_flat
);
   for (genvar w = 0; w < NW; w++) begin : g_row
      logic [NR-1:0] row_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            row_q <= '0;
         end else begin
            if (clr_en && clr_warp == WW'(w)) row_q[clr_reg] <= 1'b0;
            if (set_en && set_warp == WW'(w)) row_q[set_reg] <= 1'b1;
         end
      end
      assign busy_flat[w*NR +: NR] = row_q;
   end
endmodule

// File: rtl/ws_picker.sv
module ws_picker #(
   parameter int NW = 16,
   localparam int WW = (NW > 1) ? $clog2(NW) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NW-1:0] req,
   input  ws_pkg::pri_mode_e mode,
   input  logic          advance,
   output logic          any,
   output logic [WW-1:0] idx
);
   logic [WW-1:0] last_q;

   function automatic int scan_pos(input int i, input logic [WW-1:0] last, input logic fixed);
      if (fixed) return i;
      return (int'(last) + 1 + i) % NW;
   endfunction

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NW - 1; i >= 0; i--) begin
         if (req[scan_pos(i, last_q, mode == ws_pkg::PRI_FIXED)]) begin
            any = 1'b1;
            idx = WW'(scan_pos(i, last_q, mode == ws_pkg::PRI_FIXED));
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                last_q <= WW'(NW - 1);
      else if (advance && any)   last_q <= idx;
   end
endmodule

// File: rtl/ws_beat_seq.sv
module ws_beat_seq #(
   parameter int NW    = 16,
   parameter int IW    = 32,
   parameter int BEATS = 4,
   localparam int WW = (NW > 1) ? $clog2(NW) : 1,
   localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_any,
   input  logic [WW-1:0] win_idx,
   input  logic [IW-1:0] win_instr,
   output logic          slot_open,
   output logic          busy,
   output logic [BW-1:0] beat,
   output logic [WW-1:0] warp,
   output logic [IW-1:0] instr,
   output logic          stall
);
   localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

   assign slot_open = rst_n && (!busy || beat == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         beat  <= '0;
         warp  <= '0;
         instr <= '0;
         stall <= 1'b0;
      end else if (slot_open) begin
         beat <= '0;
         if (win_any) begin
            busy  <= 1'b1;
            warp  <= win_idx;
            instr <= win_instr;
            stall <= 1'b0;
         end else begin
            busy  <= 1'b0;
            stall <= 1'b1;
         end
      end else begin
         beat <= beat + 1'b1;
      end
   end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
   parameter int NUM_WARPS = 16,
   parameter int NUM_REGS  = 16,
   parameter int INSTR_W   = 32,
   parameter int WARP_SIZE = 32,
   parameter int LANES     = 8,
   localparam int BEATS = WARP_SIZE / LANES,
   localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_WARPS-1:0]    warp_valid,
   input  logic [NUM_WARPS*INSTR_W-1:0] instr_flat,
   input  logic [NUM_WARPS*RW-1:0] src_a_flat,
   input  logic [NUM_WARPS*RW-1:0] src_b_flat,
   input  logic [NUM_WARPS*RW-1:0] dst_flat,
   input  logic                    wb_valid,
   input  logic [WW-1:0]           wb_warp,
   input  logic [RW-1:0]           wb_reg,
   input  logic                    prio_mode,
   output logic [NUM_WARPS-1:0]    warp_ack,
   output logic                    issue_valid,
   output logic [WW-1:0]           issue_warp,
   output logic [INSTR_W-1:0]      issue_instr,
   output logic [BW-1:0]           issue_beat,
   output logic                    idle
);
   if (WARP_SIZE % LANES != 0) begin : g_bad_lanes
      $error("WARP_SIZE must be a multiple of LANES");
   end
   if (NUM_REGS != (1 << RW) || NUM_WARPS != (1 << WW)) begin : g_bad_pow2
      $error("NUM_REGS and NUM_WARPS must be powers of two");
   end
   if (NUM_WARPS < 2) begin : g_bad_pool
      $error("NUM_WARPS must be at least 2");
   end

   logic [NUM_WARPS*NUM_REGS-1:0] busy_flat;
   logic [NUM_WARPS-1:0]          ready;
   logic                          win_any;
   logic [WW-1:0]                 win_idx;
   logic                          slot_open;
   logic                          take;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ready
      logic [NUM_REGS-1:0] row;
      assign row = busy_flat[w*NUM_REGS +: NUM_REGS];
      assign ready[w] = warp_valid[w]
                      & ~row[src_a_flat[w*RW +: RW]]
                      & ~row[src_b_flat[w*RW +: RW]]
                      & ~row[dst_flat[w*RW +: RW]];
   end

   assign take     = slot_open & win_any;
   assign warp_ack = take ? (NUM_WARPS'(1) << win_idx) : '0;

   ws_scoreboard #(.NW(NUM_WARPS), .NR(NUM_REGS)) u_sb (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (take),
      .set_warp  (win_idx),
      .set_reg   (dst_flat[win_idx*RW +: RW]),
      .clr_en    (wb_valid),
      .clr_warp  (wb_warp),
      .clr_reg   (wb_reg),
      .busy_flat (busy_flat)
   );

   ws_picker #(.NW(NUM_WARPS)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (ready),
      .mode    (ws_pkg::pri_mode_e'(prio_mode)),
      .advance (slot_open),
      .any     (win_any),
      .idx     (win_idx)
   );

   ws_beat_seq #(.NW(NUM_WARPS), .IW(INSTR_W), .BEATS(BEATS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_any   (win_any),
      .win_idx   (win_idx),
      .win_instr (instr_flat[win_idx*INSTR_W +: INSTR_W]),
      .slot_open (slot_open),
      .busy      (issue_valid),
      .beat      (issue_beat),
      .warp      (issue_warp),
      .instr     (issue_instr),
      .stall     (idle)
   );
endmodule

// File: rtl/ws_issue_chk.sv
module ws_issue_chk #(
   parameter int NUM_WARPS = 16,
   parameter int INSTR_W   = 32,
   parameter int WARP_SIZE = 32,
   parameter int LANES     = 8,
   localparam int BEATS = WARP_SIZE / LANES,
   localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_WARPS-1:0] warp_valid,
   input logic [NUM_WARPS-1:0] warp_ack,
   input logic                 issue_valid,
   input logic [WW-1:0]        issue_warp,
   input logic [INSTR_W-1:0]   issue_instr,
   input logic [BW-1:0]        issue_beat,
   input logic                 idle
);
   localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

   // R2
   ack_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warp_ack & ~warp_valid) == '0);

   // R6
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(warp_ack));

   // R6
   ack_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|warp_ack) |=> (issue_valid && issue_beat == '0));

   // R7
   beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_beat != LAST) |=>
         (issue_valid && issue_beat == BW'($past(issue_beat) + 1'b1)
          && $stable(issue_warp) && $stable(issue_instr)));

   // R8
   slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|warp_ack) |-> (!issue_valid || issue_beat == LAST));

   // R8
   no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_beat == LAST) |=> (!issue_valid || issue_beat == '0));

   // R9
   idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(idle && issue_valid));
endmodule

bind warp_issue_sched ws_issue_chk #(
   .NUM_WARPS (NUM_WARPS),
   .INSTR_W   (INSTR_W),
   .WARP_SIZE (WARP_SIZE),
   .LANES     (LANES)
) u_chk (.*);

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
   localparam int NW = 16;
   localparam int IW = 32;
   localparam int IDLE_W = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NW-1:0] warp_valid = '0;
   logic [NW*IW-1:0] instr_flat;
   logic [NW*4-1:0]  src_a_flat, src_b_flat, dst_flat;
   logic          wb_valid = 1'b0;
   logic [3:0]    wb_warp = '0;
   logic [3:0]    wb_reg = '0;
   logic          prio_mode = 1'b0;
   logic [NW-1:0] warp_ack;
   logic          issue_valid;
   logic [3:0]    issue_warp;
   logic [IW-1:0] issue_instr;
   logic [1:0]    issue_beat;
   logic          idle;

   logic [3:0] ra [NW];
   logic [3:0] rb [NW];
   logic [3:0] rd [NW];

   int n_chk = 0;
   int n_bad = 0;
   int pend_kind = 0;   // 0 none, 1 idle due, 2 final beat due
   int pend_warp = 0;

   always #5 clk = ~clk;

   function automatic logic [IW-1:0] instr_of(input int w);
      return 32'h5A00_0000 + 32'(w) * 32'h0001_0101;
   endfunction

   always_comb begin
      for (int w = 0; w < NW; w++) begin
         instr_flat[w*IW +: IW] = instr_of(w);
         src_a_flat[w*4 +: 4]   = ra[w];
         src_b_flat[w*4 +: 4]   = rb[w];
         dst_flat[w*4 +: 4]     = rd[w];
      end
   end

   warp_issue_sched i_warp_issue_sched (
      .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .instr_flat(instr_flat),
      .src_a_flat(src_a_flat), .src_b_flat(src_b_flat), .dst_flat(dst_flat),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg), .prio_mode(prio_mode),
      .warp_ack(warp_ack), .issue_valid(issue_valid), .issue_warp(issue_warp),
      .issue_instr(issue_instr), .issue_beat(issue_beat), .idle(idle)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_pending();
      if (pend_kind == 1) begin
         chk("R9 idle after empty slot", {idle, issue_valid}, 2'b10);
      end else if (pend_kind == 2) begin
         chk("R7 final beat", {issue_valid, issue_beat, issue_warp}, {1'b1, 2'd3, 4'(pend_warp)});
      end
   endtask

   // One issue slot: caller is at a falling edge that is a selection cycle.
   task automatic run_slot(input logic [15:0] vmask, input logic fixed, input logic wbe,
                           input int wbw, input int wbr, input int exp, input string tag);
      check_pending();
      warp_valid = vmask;
      prio_mode  = fixed;
      wb_valid   = wbe;
      wb_warp    = 4'(wbw);
      wb_reg     = 4'(wbr);
      #1;
      chk(tag, 64'(warp_ack), (exp == IDLE_W) ? 64'd0 : (64'd1 << exp));
      @(negedge clk);
      wb_valid = 1'b0;
      if (exp == IDLE_W) begin
         pend_kind = 1;
      end else begin
         for (int b = 0; b < 3; b++) begin
            chk("R7 beat", {issue_valid, issue_beat, issue_warp, issue_instr},
                {1'b1, 2'(b), 4'(exp), instr_of(exp)});
            @(negedge clk);
         end
         pend_kind = 2;
         pend_warp = exp;
      end
   endtask

   // vector: {valid mask, fixed mode, wb enable, wb warp, expected winner (31 = none)}
   localparam int NVEC = 17;
   localparam logic [26:0] VEC [NVEC] = '{
      {16'h0000, 1'b0, 1'b0, 4'd0,  5'd31},  // R9 nothing valid
      {16'h0001, 1'b0, 1'b0, 4'd0,  5'd0},   // R4 first search from warp 0
      {16'h0003, 1'b0, 1'b0, 4'd0,  5'd1},   // R3 warp 0 dst busy
      {16'h0003, 1'b0, 1'b0, 4'd0,  5'd31},  // R2 both blocked
      {16'h0003, 1'b0, 1'b1, 4'd0,  5'd31},  // R3 writeback not yet seen
      {16'h0003, 1'b0, 1'b0, 4'd0,  5'd0},   // R3 writeback now seen
      {16'h0003, 1'b0, 1'b1, 4'd1,  5'd31},  // R3 same-cycle writeback ignored
      {16'h0013, 1'b1, 1'b0, 4'd0,  5'd1},   // R5 lowest ready index
      {16'h0090, 1'b0, 1'b0, 4'd0,  5'd4},   // R4 after warp 1
      {16'h0090, 1'b0, 1'b0, 4'd0,  5'd7},   // R4 after warp 4
      {16'h8001, 1'b0, 1'b0, 4'd0,  5'd15},  // R4 warp 0 still busy
      {16'h0800, 1'b1, 1'b1, 4'd0,  5'd11},  // R5 single candidate
      {16'h0401, 1'b0, 1'b0, 4'd0,  5'd0},   // R4 wrap past 15 to 0
      {16'h0400, 1'b0, 1'b0, 4'd0,  5'd10},  // R4
      {16'hFFFF, 1'b1, 1'b0, 4'd0,  5'd2},   // R5 all valid, fixed
      {16'hFFFF, 1'b0, 1'b0, 4'd0,  5'd3},   // R4 all valid, rotating
      {16'h0000, 1'b0, 1'b0, 4'd0,  5'd31}   // R9
   };

   initial begin
      for (int w = 0; w < NW; w++) begin
         ra[w] = 4'((w + 1) % NW);
         rb[w] = 4'((w + 2) % NW);
         rd[w] = 4'(w);
      end
      // R1 reset state
      warp_valid = '1;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset outputs", {issue_valid, idle, warp_ack}, '0);
      warp_valid = '0;
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         run_slot(VEC[i][26:11], VEC[i][10], VEC[i][9], int'(VEC[i][8:5]), int'(VEC[i][8:5]),
                  int'(VEC[i][4:0]), $sformatf("R4/R5/R6 vector %0d ack", i));
      end

      // R2 source hazards on warp 5
      run_slot(16'h0020, 1'b0, 1'b0, 0, 0, 5, "R6 warp 5 first issue");
      ra[5] = 4'd5; rd[5] = 4'd9;
      run_slot(16'h0020, 1'b0, 1'b0, 0, 0, IDLE_W, "R2 first source busy");
      run_slot(16'h0020, 1'b0, 1'b1, 5, 5, IDLE_W, "R3 writeback same cycle");
      run_slot(16'h0020, 1'b0, 1'b0, 0, 0, 5, "R3 writeback released");
      ra[5] = 4'd6; rb[5] = 4'd9; rd[5] = 4'd12;
      run_slot(16'h0020, 1'b0, 1'b1, 5, 9, IDLE_W, "R2 second source busy");
      run_slot(16'h0020, 1'b0, 1'b0, 0, 0, 5, "R3 second source released");

      // R1 reset in mid-issue clears scoreboard and pointer
      check_pending();
      rst_n = 1'b0;
      warp_valid = '1;
      @(negedge clk);
      #1;
      chk("R1 reset mid-run", {issue_valid, idle, warp_ack}, '0);
      rst_n = 1'b1;
      pend_kind = 0;
      run_slot(16'h0003, 1'b0, 1'b0, 0, 0, 0, "R1 pointer and scoreboard cleared");
      run_slot(16'h0000, 1'b0, 1'b0, 0, 0, IDLE_W, "R9 drain");
      check_pending();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule